// File: doc/BRIEF.md
# Non-Volatile Byte Store Register Controller

This block lets a CPU reach a byte-wide non-volatile data store of 4096 locations through four small I/O registers: an address low byte, an address high byte, a data byte and a control byte. The store is held in an internal register array. Software loads the address, then sets a control bit to read one byte into the data register. To write, it loads the data register, arms the block, and then sets the write strobe. While each access is set up, the block drives a stall output so that the CPU holds back its next instruction. Reads stall longer than writes.

A write is self-timed. The write strobe bit stays set for a programmable number of cycles and clears itself in hardware when the byte has been committed. Software can poll that bit to know when the next byte may be written. The arming step guards against stray register writes. An arm bit opens a short window, and a strobe outside that window has no effect. While a write is in flight, further reads, address changes and data changes are refused, so the pending byte cannot be disturbed. An optional interrupt line reports that the store is ready.

Register select encoding: 0 = address low, 1 = address high, 2 = data, 3 = control. The control byte uses these bits: bit 0 read strobe / read active, bit 1 write strobe / write busy, bit 2 arm, bit 3 interrupt enable. Bits 7..4 read zero.

Top module: `nvm_regif`

## Requirements
- R1: A byte written to an address is returned in the data register (select 2) by a later read of the same address. Different addresses hold independent bytes, including address 0x000 and address 0xFFF.
- R2: Select 0 reads and writes address bits 7..0. Select 1 writes address bits 11..8 from data bits 3..0, and reads them back in bits 3..0 with bits 7..4 always zero, whatever was written there.
- R3: Writing control bit 0 = 1 while idle drives stall_o high for exactly 4 cycles, starting with the cycle after the write. Control bit 0 reads 1 during those cycles and 0 afterwards. The addressed byte is in the data register from the first cycle after the stall.
- R4: A write that is accepted drives stall_o high for exactly 2 cycles, starting with the cycle after the strobe.
- R5: After an accepted write, control bit 1 reads 1 for exactly WRITE_CYCLES cycles and then clears by itself. The array holds the new byte once the bit clears. After reset the control byte reads 0x00 and stall_o is low.
- R6: Writing control bit 2 = 1 arms the block, and bit 2 then reads 1 for exactly 4 cycles. A write strobe (control bit 1) is accepted only when it lands in one of those 4 cycles. A strobe one cycle later causes no busy, no stall and no change to the array. Accepting a write clears the arm bit.
- R7: A read strobe issued while a write is busy causes no stall and leaves the data register unchanged.
- R8: Writes to the address or data registers while a write is busy are ignored. The in-flight write commits the address and data that were present when it started.
- R9: irq_o is high exactly when control bit 3 (interrupt enable) is 1 and no write is busy. It is low after reset.
- R10: A single control write that sets both strobes while the block is armed starts only the write (2-cycle stall, no read activity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable, sampled on the clock edge |
| reg_sel_i | input | 2 | Register select (0 addr low, 1 addr high, 2 data, 3 control) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read view of the selected register, combinational |
| stall_o | output | 1 | CPU stall request after a read or write access |
| irq_o | output | 1 | Ready interrupt: enabled and no write busy |

## Verification
The bench builds the block with WRITE_CYCLES set to 6 and keeps the default 12-bit address, 4-cycle read stall, 2-cycle write stall and 4-cycle arm window. The short write time lets the bench see the complete busy interval and its self-clearing many times within a short run. It also leaves room to poke the address, data and read strobe between the end of the write stall and the end of busy. The full 12-bit address means that the top location 0xFFF and the nibble masking of the high byte are both exercised on the real width.

// File: rtl/nvm_regif_pkg.sv
package nvm_regif_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_RD  = 0;
  localparam int unsigned CB_WR  = 1;
  localparam int unsigned CB_ARM = 2;
  localparam int unsigned CB_IE  = 3;

  // Control byte as seen by software; the upper nibble is always zero.
  function automatic logic [7:0] pack_ctrl(input logic ie, input logic armed,
                                           input logic busy, input logic rd_act);
    logic [7:0] v;
    v         = 8'h00;
    v[CB_IE]  = ie;
    v[CB_ARM] = armed;
    v[CB_WR]  = busy;
    v[CB_RD]  = rd_act;
    return v;
  endfunction

  // High address byte view from a zero-extended 16-bit address.
  function automatic logic [7:0] hi_view(input logic [15:0] a);
    return a[15:8];
  endfunction

endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/nvm_addr_reg.sv
module nvm_addr_reg #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [7:0]        lo_i,
  input  logic [ADDR_W-9:0] hi_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (!lock_i) begin
      if (we_lo_i) lo_q <= lo_i;
      if (we_hi_i) hi_q <= hi_i;
    end
  end

  assign addr_o = {hi_q, lo_q};

  // R8: address cannot move while an access holds the lock
  a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(addr_o));

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq #(
  parameter int unsigned WRITE_CYCLES = 40,
  parameter int unsigned RD_STALL     = 4,
  parameter int unsigned WR_STALL     = 2,
  parameter int unsigned ARM_WINDOW   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_rd_i,
  input  logic req_wr_i,
  input  logic req_arm_i,
  output logic rd_start_o,
  output logic rd_done_o,
  output logic wr_start_o,
  output logic wr_done_o,
  output logic busy_o,
  output logic rd_active_o,
  output logic armed_o,
  output logic stall_o,
  output logic locked_o
);
  localparam int unsigned RC_W = $clog2(RD_STALL + 1);
  localparam int unsigned SC_W = $clog2(WR_STALL + 1);
  localparam int unsigned WC_W = $clog2(WRITE_CYCLES + 1);
  localparam int unsigned AC_W = $clog2(ARM_WINDOW + 1);

  logic [RC_W-1:0] rd_cnt_q;
  logic [SC_W-1:0] ws_cnt_q;
  logic [WC_W-1:0] wr_cnt_q;
  logic [AC_W-1:0] arm_cnt_q;

  assign rd_active_o = rd_cnt_q != '0;
  assign busy_o      = wr_cnt_q != '0;
  assign armed_o     = arm_cnt_q != '0;
  assign stall_o     = rd_active_o || (ws_cnt_q != '0);
  assign locked_o    = stall_o || busy_o;

  assign wr_start_o = req_wr_i && armed_o && !locked_o;
  assign rd_start_o = req_rd_i && !locked_o && !wr_start_o;
  assign rd_done_o  = rd_cnt_q == RC_W'(1);
  assign wr_done_o  = wr_cnt_q == WC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q  <= '0;
      ws_cnt_q  <= '0;
      wr_cnt_q  <= '0;
      arm_cnt_q <= '0;
    end else begin
      if (rd_start_o)       rd_cnt_q <= RC_W'(RD_STALL);
      else if (rd_active_o) rd_cnt_q <= rd_cnt_q - RC_W'(1);

      if (wr_start_o)            ws_cnt_q <= SC_W'(WR_STALL);
      else if (ws_cnt_q != '0)   ws_cnt_q <= ws_cnt_q - SC_W'(1);

      if (wr_start_o)  wr_cnt_q <= WC_W'(WRITE_CYCLES);
      else if (busy_o) wr_cnt_q <= wr_cnt_q - WC_W'(1);

      if (wr_start_o)     arm_cnt_q <= '0;
      else if (req_arm_i) arm_cnt_q <= AC_W'(ARM_WINDOW);
      else if (armed_o)   arm_cnt_q <= arm_cnt_q - AC_W'(1);
    end
  end

  // Stall run-length tracker feeding the length assertions
  logic [7:0] run_q;
  logic       kind_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      kind_rd_q <= 1'b0;
    end else begin
      run_q <= stall_o ? run_q + 8'd1 : 8'd0;
      if (rd_start_o)      kind_rd_q <= 1'b1;
      else if (wr_start_o) kind_rd_q <= 1'b0;
    end
  end

  // R3: a read stall lasts exactly RD_STALL cycles
  a_r3_read_stall_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stall_o) && kind_rd_q) |-> (run_q == 8'(RD_STALL)));

  // R4: a write stall lasts exactly WR_STALL cycles
  a_r4_write_stall_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stall_o) && !kind_rd_q) |-> (run_q == 8'(WR_STALL)));

  // R3: a read start raises the stall on the next cycle
  a_r3_read_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_o |=> (stall_o && rd_active_o));

  // R5: the busy flag drops right after the commit cycle
  a_r5_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !busy_o);

  // R6: busy can only begin from an armed state
  a_r6_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(armed_o));

  // R6: accepting a write consumes the arm
  a_r6_arm_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |=> (busy_o && !armed_o));

  // R7: no read activity begins while a write is busy
  a_r7_no_read_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !$rose(rd_active_o));

  // R10: both strobes together start only the write
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rd_i && wr_start_o) |=> !rd_active_o);

endmodule

// File: rtl/nvm_regif.sv
module nvm_regif import nvm_regif_pkg::*; #(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned WRITE_CYCLES = 40,
  parameter int unsigned RD_STALL     = 4,
  parameter int unsigned WR_STALL     = 2,
  parameter int unsigned ARM_WINDOW   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       stall_o,
  output logic       irq_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel_i);

  logic ctl_we;
  assign ctl_we = reg_we_i && (sel == SEL_CTRL);

  // Internal events brought out as named wires
  logic rd_start, rd_done, wr_start, wr_done;
  logic busy, rd_active, armed, locked;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        mem_rdata;
  logic [7:0]        data_q;
  logic              ie_q;

  nvm_seq #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .RD_STALL    (RD_STALL),
    .WR_STALL    (WR_STALL),
    .ARM_WINDOW  (ARM_WINDOW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_rd_i   (ctl_we && reg_wdata_i[CB_RD]),
    .req_wr_i   (ctl_we && reg_wdata_i[CB_WR]),
    .req_arm_i  (ctl_we && reg_wdata_i[CB_ARM]),
    .rd_start_o (rd_start),
    .rd_done_o  (rd_done),
    .wr_start_o (wr_start),
    .wr_done_o  (wr_done),
    .busy_o     (busy),
    .rd_active_o(rd_active),
    .armed_o    (armed),
    .stall_o    (stall_o),
    .locked_o   (locked)
  );

  nvm_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (locked),
    .we_lo_i(reg_we_i && (sel == SEL_ADDR_LO)),
    .we_hi_i(reg_we_i && (sel == SEL_ADDR_HI)),
    .lo_i   (reg_wdata_i),
    .hi_i   (reg_wdata_i[HI_W-1:0]),
    .addr_o (addr)
  );

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk_i  (clk_i),
    .we_i   (wr_done),
    .addr_i (addr),
    .wdata_i(data_q),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (rd_done) data_q <= mem_rdata;
      else if (reg_we_i && (sel == SEL_DATA) && !locked) data_q <= reg_wdata_i;
      if (ctl_we) ie_q <= reg_wdata_i[CB_IE];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ADDR_LO: reg_rdata_o = addr[7:0];
      SEL_ADDR_HI: reg_rdata_o = hi_view(16'(addr));
      SEL_DATA:    reg_rdata_o = data_q;
      default:     reg_rdata_o = pack_ctrl(ie_q, armed, busy, rd_active);
    endcase
  end

  assign irq_o = ie_q && !busy;

  // R2: the high address view never shows bits above the address width
  a_r2_hi_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_ADDR_HI) |-> ((reg_rdata_o >> HI_W) == 8'h00));

  // R1: the committed byte is readable at the same address next cycle
  a_r1_commit_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> (mem_rdata == $past(data_q)));

  // R8: data register is frozen while a write is busy
  a_r8_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(data_q));

  // R9: no ready interrupt while a write is busy
  a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !irq_o);

endmodule

// File: tb/nvm_regif_test.sv
module nvm_regif_test;
  localparam int WC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_we = 1'b0;
  logic [1:0] tb_sel = 2'd0;
  logic [7:0] tb_wd = 8'h00;
  logic [7:0] reg_rdata;
  logic       stall_o, irq_o;

  always #5 clk = ~clk;

  nvm_regif #(.WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(tb_we), .reg_sel_i(tb_sel),
    .reg_wdata_i(tb_wd), .reg_rdata_o(reg_rdata), .stall_o(stall_o), .irq_o(irq_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int stall_acc, busy_acc, arm_acc, rd_acc, irq_low_acc;

  // Behavioural reference model
  logic [7:0] m_mem [int];
  int  m_addr, m_data, m_rd, m_ws, m_wr, m_arm;
  bit  m_ie, m_lo_ok, m_hi_ok, m_data_ok;
  bit  f_ctl, f_locked, f_wstart, f_rstart;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rd = 0; m_ws = 0; m_wr = 0; m_arm = 0; m_ie = 0;
      m_lo_ok = 0; m_hi_ok = 0; m_data_ok = 0;
    end else begin
      f_ctl    = tb_we && (tb_sel == 2'd3);
      f_locked = (m_rd != 0) || (m_ws != 0) || (m_wr != 0);
      f_wstart = f_ctl && tb_wd[1] && (m_arm != 0) && !f_locked;
      f_rstart = f_ctl && tb_wd[0] && !f_locked && !f_wstart;
      if (m_rd == 1) begin
        if (m_lo_ok && m_hi_ok && m_mem.exists(m_addr)) begin
          m_data = m_mem[m_addr]; m_data_ok = 1;
        end else m_data_ok = 0;
      end
      if (m_wr == 1 && m_lo_ok && m_hi_ok) begin
        if (m_data_ok) m_mem[m_addr] = m_data[7:0];
        else m_mem.delete(m_addr);
      end
      if (f_rstart) m_rd = 4; else if (m_rd != 0) m_rd--;
      if (f_wstart) begin m_ws = 2; m_wr = WC; end
      else begin
        if (m_ws != 0) m_ws--;
        if (m_wr != 0) m_wr--;
      end
      if (f_wstart) m_arm = 0;
      else if (f_ctl && tb_wd[2]) m_arm = 4;
      else if (m_arm != 0) m_arm--;
      if (tb_we && !f_locked) begin
        if (tb_sel == 2'd0) begin m_addr = (m_addr & 'hF00) | tb_wd; m_lo_ok = 1; end
        if (tb_sel == 2'd1) begin m_addr = (m_addr & 'h0FF) | ((tb_wd & 'hF) << 8); m_hi_ok = 1; end
        if (tb_sel == 2'd2) begin m_data = tb_wd; m_data_ok = 1; end
      end
      if (f_ctl) m_ie = tb_wd[3];
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(stall_o, (m_rd != 0) || (m_ws != 0), "R3,R4 stall output");
    chk(irq_o, m_ie && (m_wr == 0), "R9 irq output");
    case (tb_sel)
      2'd0: if (m_lo_ok) chk(reg_rdata, m_addr & 'hFF, "R2 addr low view");
      2'd1: if (m_hi_ok) chk(reg_rdata, (m_addr >> 8) & 'hF, "R2 addr high view");
      2'd2: if (m_data_ok) chk(reg_rdata, m_data, "R1 data view");
      default: chk(reg_rdata, {4'b0, m_ie, m_arm != 0, m_wr != 0, m_rd != 0}, "R5 control view");
    endcase
    if (stall_o) stall_acc++;
    if (!irq_o) irq_low_acc++;
    if (tb_sel == 2'd3) begin
      if (reg_rdata[1]) busy_acc++;
      if (reg_rdata[2]) arm_acc++;
      if (reg_rdata[0]) rd_acc++;
    end
  endtask

  task automatic cycle(input bit we, input logic [1:0] sel, input logic [7:0] wd);
    @(negedge clk);
    if (rst_n) compare_all();
    tb_we = we; tb_sel = sel; tb_wd = wd;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] wd);
    cycle(1'b1, sel, wd);
  endtask

  task automatic idle(input int n, input logic [1:0] sel);
    for (int i = 0; i < n; i++) cycle(1'b0, sel, 8'h00);
  endtask

  task automatic expect_rd(input logic [1:0] sel, input int exp, input string tag);
    cycle(1'b0, sel, 8'h00);
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic set_addr(input int a);
    wr(2'd0, a[7:0]);
    wr(2'd1, 8'(a >> 8));
  endtask

  task automatic do_write(input int a, input logic [7:0] v, input bit ie);
    set_addr(a);
    wr(2'd2, v);
    wr(2'd3, {4'b0, ie, 3'b100});
    stall_acc = 0; busy_acc = 0; irq_low_acc = 0;
    wr(2'd3, {4'b0, ie, 3'b010});
    idle(WC + 2, 2'd3);
  endtask

  task automatic do_read(input int a);
    set_addr(a);
    stall_acc = 0; rd_acc = 0;
    wr(2'd3, 8'h01);
    idle(6, 2'd3);
    chk(stall_acc, 4, "R3 read stall length");
    chk(rd_acc, 4, "R3 read flag duration");
  endtask

  bit finished = 0;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state (R5, R9)
    expect_rd(2'd3, 8'h00, "R5 reset control");
    chk(stall_o, 0, "R3 reset stall");
    chk(irq_o, 0, "R9 reset irq");

    // R2 masking of high address byte
    wr(2'd1, 8'hA7);
    expect_rd(2'd1, 8'h07, "R2 high nibble masked");
    wr(2'd0, 8'h5E);
    expect_rd(2'd0, 8'h5E, "R2 low byte");

    // R1, R4, R5 write at the top address
    do_write('hFFF, 8'h3C, 1'b0);
    chk(stall_acc, 2, "R4 write stall length");
    chk(busy_acc, WC, "R5 busy duration");
    do_write('h000, 8'hC3, 1'b0);
    do_read('hFFF);
    expect_rd(2'd2, 8'h3C, "R1 readback 0xFFF");
    do_read('h000);
    expect_rd(2'd2, 8'hC3, "R1 readback 0x000");

    // R6 strobe one cycle after the window closes
    do_write('h123, 8'h11, 1'b0);
    wr(2'd2, 8'h77);
    wr(2'd3, 8'h04);
    arm_acc = 0;
    idle(4, 2'd3);
    chk(arm_acc, 4, "R6 arm window length");
    stall_acc = 0; busy_acc = 0;
    wr(2'd3, 8'h02);
    idle(4, 2'd3);
    chk(busy_acc, 0, "R6 late strobe no busy");
    chk(stall_acc, 0, "R6 late strobe no stall");
    do_read('h123);
    expect_rd(2'd2, 8'h11, "R6 array unchanged");

    // R6 strobe in the last window cycle
    wr(2'd2, 8'h99);
    wr(2'd3, 8'h04);
    idle(3, 2'd3);
    busy_acc = 0;
    wr(2'd3, 8'h02);
    idle(WC + 2, 2'd3);
    chk(busy_acc, WC, "R6 last-cycle strobe accepted");
    expect_rd(2'd3, 8'h00, "R6 arm cleared after write");
    do_read('h123);
    expect_rd(2'd2, 8'h99, "R6 committed byte");

    // R7 read strobe during busy
    set_addr('h200);
    wr(2'd2, 8'h5A);
    wr(2'd3, 8'h04);
    wr(2'd3, 8'h02);
    idle(3, 2'd3);
    stall_acc = 0; rd_acc = 0;
    wr(2'd3, 8'h01);
    idle(WC, 2'd3);
    chk(stall_acc, 0, "R7 busy read no stall");
    chk(rd_acc, 0, "R7 busy read no activity");
    expect_rd(2'd2, 8'h5A, "R7 data untouched");

    // R8 address/data writes during busy
    set_addr('h300);
    wr(2'd2, 8'h44);
    wr(2'd3, 8'h04);
    wr(2'd3, 8'h02);
    idle(2, 2'd3);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'hEE);
    wr(2'd1, 8'h0F);
    idle(WC, 2'd3);
    expect_rd(2'd0, 8'h00, "R8 addr low frozen");
    expect_rd(2'd1, 8'h03, "R8 addr high frozen");
    expect_rd(2'd2, 8'h44, "R8 data frozen");
    do_read('h300);
    expect_rd(2'd2, 8'h44, "R8 original byte committed");

    // R9 ready interrupt
    wr(2'd3, 8'h08);
    idle(1, 2'd3);
    chk(irq_o, 1, "R9 irq when enabled and idle");
    do_write('h055, 8'h66, 1'b1);
    chk(irq_low_acc, WC, "R9 irq low while busy");
    chk(irq_o, 1, "R9 irq back after write");
    wr(2'd3, 8'h00);
    idle(1, 2'd3);
    chk(irq_o, 0, "R9 irq off when disabled");

    // R10 both strobes while armed
    set_addr('h0AB);
    wr(2'd2, 8'h21);
    wr(2'd3, 8'h04);
    stall_acc = 0; busy_acc = 0; rd_acc = 0;
    wr(2'd3, 8'h03);
    idle(WC + 2, 2'd3);
    chk(stall_acc, 2, "R10 write stall only");
    chk(busy_acc, WC, "R10 write started");
    chk(rd_acc, 0, "R10 no read activity");
    do_read('h0AB);
    expect_rd(2'd2, 8'h21, "R10 byte written");

    idle(2, 2'd3);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule